// File: doc/BRIEF.md
# Line-rate successive-approximation converter sequencer

This block is the digital half of a 6-bit successive-approximation converter that measures one integrated video level per scan line. Each horizontal-drive pulse asks the analog front end to sample and hold the integrated value of the line that just ended. The block then drives a trial code into an external DAC, reads one comparator decision per conversion clock, and settles the code from the most significant bit down.

The settled code and a white-peak flag are shifted out as a 7-bit serial word with a data-valid strobe. The peak flag is set if the line held any level above the 50 IRE threshold. Because the conversion follows the line it measures, each word describes the previous line. A new horizontal-drive pulse always wins: it abandons any conversion or serial word in progress and starts over.

The state machine has four states. `ST_IDLE` waits for a pulse. `ST_SAMPLE` raises the hold strobe and loads the first trial code. `ST_TRIAL` decides one bit per clock. `ST_SHIFT` sends the word. The transitions are as follows:
- IDLE→SAMPLE on a pulse.
- SAMPLE→TRIAL with no pulse, or SAMPLE→SAMPLE on a pulse.
- TRIAL→TRIAL while bits remain, TRIAL→SHIFT after the last bit, or TRIAL→SAMPLE on a pulse (abort).
- SHIFT→SHIFT while bits remain, SHIFT→IDLE after the seventh bit, or SHIFT→SAMPLE on a pulse (abort).

Top module: `line_sar_serializer`

## Requirements
- R1: After reset, `dac_code` is 0, and `sh_strobe`, `ser_valid` and `ser_data` are low.
- R2: `hd_pulse` is sampled at a clock edge. For that edge, `sh_strobe` is high for exactly the following clock cycle. If no further pulse arrives, it is low in the cycle after that.
- R3: In the cycle after the hold strobe, `dac_code` is 6'b100000. One bit is then decided per clock, from bit 5 down to bit 0. A trial bit stays 1 when `cmp_ge` is high, meaning the held level is at or above the code, and is cleared otherwise. The next lower bit is set as the new trial.
- R4: The converted result is the largest code c for which the held level is at or above c. The value 00 means a black line and 3F means a white line.
- R5: The serial word is 7 bits, sent with the peak flag first, then result bit 5 down to bit 0. `ser_valid` is high for exactly 7 consecutive cycles, the first of which is 8 cycles after the edge that sampled the pulse. `ser_data` is 0 whenever `ser_valid` is low.
- R6: The peak flag is a sticky capture of `peak_in` over all edges after one pulse edge and before the next. `peak_in` at the edge that samples the pulse is ignored. The flag is cleared by that edge.
- R7: A pulse during the search or during serialisation abandons it. The abandoned word is never sent. `ser_valid` is low in the cycle after the pulse edge, and a full new conversion follows.
- R8: Once serialisation has started, `dac_code` holds the converted result until the next hold strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_pulse | input | 1 | Horizontal-drive line-start pulse, one clock wide |
| cmp_ge | input | 1 | Comparator result: held level at or above `dac_code` |
| peak_in | input | 1 | Raw detector output, high while video exceeds 50 IRE |
| dac_code | output | 6 | Trial or settled code for the external DAC |
| sh_strobe | output | 1 | Sample-and-hold command for the integrator |
| ser_data | output | 1 | Serial word bit |
| ser_valid | output | 1 | High for each of the 7 serial bit periods |

## Verification
The bench converts lines at the extreme levels 00 and 3F and at the midpoint neighbours 1F and 20. An off-by-one comparison rule or a wrong trial order would return a neighbouring code at these levels. It drives `peak_in` high only on the pulse cycle to expose a latch that leaks into the wrong line, and also on the final cycles of a line to catch a latch that is cleared too early. Pulses that land inside the search and inside the shift phase show whether a stale word or a partial strobe run escapes. Counting the valid cycles catches a shifter that sends six or eight bits.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2,
        ST_SHIFT  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_bit_search.sv
// Successive-approximation code register: one decision per step, MSB first.
module sar_bit_search #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic         cmp_ge,
    output logic [W-1:0] code,
    output logic [W-1:0] resolved,
    output logic         last
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [IW-1:0] idx;
    logic [W-1:0]  trial_next;

    // Current code with the bit under test settled by the comparator.
    always_comb begin
        resolved = code;
        if (!cmp_ge) resolved[idx] = 1'b0;
    end

    // Settled code plus the next lower trial bit.
    always_comb begin
        trial_next = resolved;
        if (idx != '0) trial_next[idx - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            idx  <= '0;
        end else if (start) begin
            code <= {1'b1, {(W-1){1'b0}}};
            idx  <= IW'(W-1);
        end else if (step) begin
            code <= trial_next;
            if (idx != '0) idx <= idx - 1'b1;
        end
    end

    assign last = (idx == '0);

endmodule

// File: rtl/peak_catcher.sv
// Sticky per-line peak capture; snapshot taken at each line start.
module peak_catcher (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic peak_in,
    output logic peak_snap
);
    logic sticky;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky    <= 1'b0;
            peak_snap <= 1'b0;
        end else if (line_start) begin
            peak_snap <= sticky;
            sticky    <= 1'b0;
        end else begin
            sticky <= sticky | peak_in;
        end
    end

endmodule

// File: rtl/word_shifter.sv
// Parallel-load shift register, MSB out first, with end-of-word flag.
module word_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] word_in,
    output logic         bit_out,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= word_in;
            cnt <= '0;
        end else if (step) begin
            sr  <= {sr[W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_out = sr[W-1];
    assign last    = (cnt == CW'(W-1));

endmodule

// File: rtl/line_sar_serializer.sv
module line_sar_serializer
    import sar_ser_pkg::*;
#(
    parameter int ADC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_pulse,
    input  logic             cmp_ge,
    input  logic             peak_in,
    output logic [ADC_W-1:0] dac_code,
    output logic             sh_strobe,
    output logic             ser_data,
    output logic             ser_valid
);
    localparam int WORD_W = ADC_W + 1;

    sar_state_e state, state_nxt;

    logic             srch_start, srch_step, srch_last;
    logic             shf_load, shf_step, shf_last, shf_bit;
    logic             peak_snap;
    logic [ADC_W-1:0] srch_resolved;
    logic             valid_int, strobe_int;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic: a line pulse always restarts the sequence
    always_comb begin
        state_nxt = state;
        if (hd_pulse) begin
            state_nxt = ST_SAMPLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nxt = ST_IDLE;
                ST_SAMPLE: state_nxt = ST_TRIAL;
                ST_TRIAL:  state_nxt = srch_last ? ST_SHIFT : ST_TRIAL;
                ST_SHIFT:  state_nxt = shf_last ? ST_IDLE : ST_SHIFT;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // Output and control decode
    always_comb begin
        strobe_int = 1'b0;
        srch_start = 1'b0;
        srch_step  = 1'b0;
        shf_load   = 1'b0;
        shf_step   = 1'b0;
        valid_int  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SAMPLE: begin
                strobe_int = 1'b1;
                srch_start = 1'b1;
            end
            ST_TRIAL: begin
                if (!hd_pulse) begin
                    srch_step = 1'b1;
                    shf_load  = srch_last;
                end
            end
            ST_SHIFT: begin
                valid_int = 1'b1;
                shf_step  = !hd_pulse;
            end
            default: ;
        endcase
    end

    sar_bit_search #(.W(ADC_W)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (srch_start),
        .step     (srch_step),
        .cmp_ge   (cmp_ge),
        .code     (dac_code),
        .resolved (srch_resolved),
        .last     (srch_last)
    );

    peak_catcher u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (hd_pulse),
        .peak_in    (peak_in),
        .peak_snap  (peak_snap)
    );

    word_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (shf_load),
        .step    (shf_step),
        .word_in ({peak_snap, srch_resolved}),
        .bit_out (shf_bit),
        .last    (shf_last)
    );

    assign sh_strobe = strobe_int;
    assign ser_valid = valid_int;
    assign ser_data  = valid_int & shf_bit;

endmodule

// File: rtl/line_sar_checker.sv
module line_sar_checker #(
    parameter int ADC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hd_pulse,
    input logic [ADC_W-1:0] dac_code,
    input logic             sh_strobe,
    input logic             ser_data,
    input logic             ser_valid
);
    localparam int WORD_W = ADC_W + 1;
    localparam int RW     = $clog2(WORD_W + 1);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= '0;
        else if (ser_valid) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hd_pulse |=> sh_strobe);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe && !hd_pulse) |=> !sh_strobe);

    assert_first_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe && !hd_pulse) |=> (dac_code == {1'b1, {(ADC_W-1){1'b0}}}));

    assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_data);

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> (run_len < RW'(WORD_W)));

    assert_run_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_valid && run_len != '0 && !$past(hd_pulse)) |-> (run_len == RW'(WORD_W)));

    assert_abort_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hd_pulse |=> !ser_valid);

    assert_hold_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !hd_pulse) |=> $stable(dac_code));

endmodule

bind line_sar_serializer line_sar_checker #(.ADC_W(ADC_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hd_pulse  (hd_pulse),
    .dac_code  (dac_code),
    .sh_strobe (sh_strobe),
    .ser_data  (ser_data),
    .ser_valid (ser_valid)
);

// File: tb/test_line_sar_serializer.sv
`timescale 1ns/1ps
module test_line_sar_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_pulse = 1'b0;
    logic       peak_in = 1'b0;
    logic [5:0] level = 6'd0;
    logic       cmp_ge;
    logic [5:0] dac_code;
    logic       sh_strobe, ser_data, ser_valid;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  acc_peak = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: held level at or above DAC code
    assign cmp_ge = (level >= dac_code);

    line_sar_serializer i_line_sar_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hd_pulse  (hd_pulse),
        .cmp_ge    (cmp_ge),
        .peak_in   (peak_in),
        .dac_code  (dac_code),
        .sh_strobe (sh_strobe),
        .ser_data  (ser_data),
        .ser_valid (ser_valid)
    );

    function automatic logic [6:0] exp_word(input bit pk, input logic [5:0] lvl);
        return {pk, lvl};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one line-start pulse; peak_hd is driven on the pulse cycle only.
    task automatic pulse(input logic [5:0] lvl, input bit peak_hd, output logic [6:0] w);
        @(negedge clk);
        level    = lvl;
        hd_pulse = 1'b1;
        peak_in  = peak_hd;
        w        = exp_word(acc_peak, lvl);
        acc_peak = 1'b0;
    endtask

    // Full line: pulse, then 24 cycles with random peak activity.
    task automatic run_line(input logic [5:0] lvl, input int peak_pct, input bit peak_hd);
        logic [6:0] w_exp;
        logic [6:0] w_got = '0;
        int first = -1;
        int nval = 0;
        bit quiet_ok = 1'b1;
        pulse(lvl, peak_hd, w_exp);
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            hd_pulse = 1'b0;
            if (i == 1) chk(sh_strobe == 1'b1, "R2 strobe after pulse", sh_strobe, 1);
            if (i == 2) begin
                chk(sh_strobe == 1'b0, "R2 strobe one cycle", sh_strobe, 0);
                chk(dac_code == 6'h20, "R3 first trial code", dac_code, 6'h20);
            end
            if (ser_valid) begin
                if (first < 0) first = i;
                w_got = {w_got[5:0], ser_data};
                nval++;
            end else if (ser_data) begin
                quiet_ok = 1'b0;
            end
            peak_in = (($urandom % 100) < peak_pct);
            if (peak_in) acc_peak = 1'b1;
        end
        chk(nval == 7, "R5 valid count", nval, 7);
        chk(first == 8, "R5 first valid cycle", first, 8);
        chk(quiet_ok, "R5 data low when not valid", 1, 0);
        chk(w_got[5:0] == lvl, "R4 conversion result", w_got[5:0], lvl);
        chk(w_got[6] == w_exp[6], "R6 peak flag", w_got[6], w_exp[6]);
        chk(dac_code == lvl, "R8 code held", dac_code, lvl);
    endtask

    // Pulse, wait k cycles, then let a new line override it.
    task automatic abort_line(input logic [5:0] lvl_a, input int k, input logic [5:0] lvl_b);
        logic [6:0] w_dummy;
        pulse(lvl_a, 1'b0, w_dummy);
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            hd_pulse = 1'b0;
            peak_in  = 1'b0;
        end
        // R7: replacement line must produce exactly one clean word for lvl_b
        run_line(lvl_b, 0, 1'b0);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5A17_0C3E);
        repeat (3) @(negedge clk);
        chk(dac_code == 6'd0, "R1 reset code", dac_code, 0);
        chk(!sh_strobe && !ser_valid && !ser_data, "R1 reset outputs",
            {sh_strobe, ser_valid, ser_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corners
        run_line(6'h00, 0, 1'b0);
        run_line(6'h3F, 0, 1'b0);
        run_line(6'h1F, 100, 1'b0);   // peak set for the following line
        run_line(6'h20, 0, 1'b0);
        run_line(6'h15, 0, 1'b1);     // R6: peak only on pulse cycle is ignored
        run_line(6'h2A, 0, 1'b0);
        abort_line(6'h11, 3, 6'h2E);  // R7: abort inside search
        abort_line(6'h05, 10, 6'h31); // R7: abort inside shift
        abort_line(6'h3F, 0, 6'h01);  // R7: back-to-back pulses

        // Random lines
        for (int n = 0; n < 40; n++) begin
            run_line(6'($urandom % 64), (($urandom % 3) == 0) ? 0 : 8, 1'($urandom % 2));
        end
        run_line(6'h00, 0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule